// File: doc/BRIEF.md
# Multi-Channel DMA Channel Register Controller

This block keeps the programmed state of eight DMA channels and decides, for each transfer request a peripheral raises, whether the transfer may go ahead. Software sees each channel as four 32-bit words: an auxiliary word, a flags word, a remaining byte count and a memory address. Each peripheral owns one request line and supplies a byte length and a direction with it.

When a request is taken, the block first clears the channel's three status flags. It then checks the request against the programmed enable and direction bits. A consistent request produces one command on the memory port, with the channel's address, the clamped length and the direction. The count register is then reduced and the terminal-count flag is set. An inconsistent request produces no command. Instead it raises the memory-error flag and a sticky per-channel bit in a shared error source word.

Address translation and the moving of data lie outside the block; only the command is issued. Concurrent requests are taken one at a time, lowest channel first.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every channel word and the error source word read as zero, and no done pulse, error pulse or memory command is asserted.
- R2: Channel c, word w (w from 0 to 3) sits at byte address 0x100 + 0x20*c + 8*w. Word 1 holds the flags, word 2 the byte count, word 3 the address, and word 0 is plain storage. A write stores all 32 bits. Read data is registered and appears one clock after the address is presented.
- R3: Reads of the error-type word at 0x208, of unmapped addresses and of channel addresses with a nonzero low three bits return zero. Writes to those addresses, and to 0x200, change no readable word.
- R4: Every accepted request first clears flag bits 8 (terminal count), 9 (memory error) and 10 (address error) of its channel.
- R5: A request to a channel whose flag bit 0 (enable) is 0 gives an error pulse on that channel's bit of req_err and issues no command. It leaves flag bit 9 set and the count unchanged.
- R6: A request whose req_to_dev value (1 = memory to device) differs from flag bit 1 is treated as inconsistent, with the same outcome as R5.
- R7: A consistent request issues one memory command. The command carries the channel number, the address word, the request direction and a length equal to the smaller of the requested length and the count word. The address word is not modified.
- R8: A consistent request sets flag bit 8, subtracts the issued length from the count word, and pulses that channel's bit of req_done in the same cycle as the command, one clock after the request is taken.
- R9: The error source word at 0x200 has bit c set by an inconsistent request on channel c. The bit stays set until reset.
- R10: When several channels request together, the lowest-numbered one is served. At most one channel is served per cycle, and no request is taken in a cycle in which a done or error pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (10) | Register byte address |
| reg_wdata | input | DW (32) | Register write data |
| reg_rdata | output | DW (32) | Registered read data for reg_addr |
| req_valid | input | NCH (8) | Per-channel transfer request, held until a pulse returns |
| req_to_dev | input | NCH (8) | Per-channel direction, 1 = memory to device |
| req_len | input | NCH*DW (256) | Per-channel requested byte length, channel c in bits c*DW +: DW |
| req_done | output | NCH (8) | One-cycle completion pulse per channel |
| req_err | output | NCH (8) | One-cycle consistency-error pulse per channel |
| mem_cmd_valid | output | 1 | One-cycle memory command strobe |
| mem_cmd_chan | output | $clog2(NCH) (3) | Channel of the command |
| mem_cmd_addr | output | DW (32) | Address word of that channel |
| mem_cmd_len | output | DW (32) | Clamped byte length |
| mem_cmd_to_dev | output | 1 | Direction of the command |

## Verification
A wrong flag or count value stays hidden until software reads the channel back. It also shows in the outcome of the next request on that channel. For example, a count that was decremented wrongly shows up as a wrong clamped length on the following memory command. A fault in arbitration or in the consistency test shows at once: in the clock after the request, the wrong channel's pulse appears, a command appears where an error was due, or a pulse appears twice in a row. The error source word holds each error. A bit that was never set, or was lost, therefore shows on any later read of 0x200.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  // flag bit positions inside channel word 1
  localparam int FLG_EN     = 0;
  localparam int FLG_TO_DEV = 1;
  localparam int FLG_TC     = 8;
  localparam int FLG_MERR   = 9;
  localparam int FLG_AERR   = 10;
  // word index inside a channel's group of four
  localparam int WORD_AUX   = 0;
  localparam int WORD_FLAGS = 1;
  localparam int WORD_COUNT = 2;
  localparam int WORD_ADDR  = 3;
  localparam int WORDS_PER_CH = 4;
  localparam int CH_STRIDE    = 32;
  typedef logic [1:0] word_idx_t;
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          any
);
  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        found   = 1'b1;
        gnt[i]  = 1'b1;
        gnt_idx = IW'(i);
      end
    end
    any = found;
  end
endmodule

// File: rtl/dma_xfer_eval.sv
module dma_xfer_eval
  import dma_chan_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] flags,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] len,
  input  logic          to_dev,
  output logic          ok,
  output logic [DW-1:0] xlen,
  output logic [DW-1:0] new_flags,
  output logic [DW-1:0] new_count
);
  localparam logic [DW-1:0] STS_MASK =
    (DW'(1) << FLG_TC) | (DW'(1) << FLG_MERR) | (DW'(1) << FLG_AERR);

  logic [DW-1:0] cleared;

  always_comb begin
    ok        = flags[FLG_EN] && (to_dev == flags[FLG_TO_DEV]);
    xlen      = (len < count) ? len : count;
    cleared   = flags & ~STS_MASK;
    new_flags = cleared | (ok ? (DW'(1) << FLG_TC) : (DW'(1) << FLG_MERR));
    new_count = ok ? (count - xlen) : count;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int DW       = 32,
  parameter int AW       = 10,
  parameter int CH_BASE  = 'h100,
  parameter int SRC_ADDR = 'h200,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          upd,
  input  logic [CW-1:0] upd_ch,
  input  logic          upd_err,
  input  logic [DW-1:0] upd_flags,
  input  logic [DW-1:0] upd_count,
  output logic [DW-1:0] flags_o [NCH],
  output logic [DW-1:0] count_o [NCH],
  output logic [DW-1:0] addr_o  [NCH],
  output logic [NCH-1:0] irq_src_o
);
  localparam logic [AW-1:0] BASE_A = AW'(CH_BASE);
  localparam logic [AW-1:0] END_A  = AW'(CH_BASE + NCH * CH_STRIDE);
  localparam logic [AW-1:0] SRC_A  = AW'(SRC_ADDR);

  logic [DW-1:0]  words [NCH][WORDS_PER_CH];
  logic [NCH-1:0] irq_src;
  logic [AW-1:0]  off;
  logic           ch_hit;
  logic [CW-1:0]  a_ch;
  word_idx_t      a_idx;
  logic [DW-1:0]  rd_val;

  // one decode serves both the write and the read path
  always_comb begin
    off    = addr - BASE_A;
    ch_hit = (addr >= BASE_A) && (addr < END_A) && (addr[2:0] == 3'b000);
    a_ch   = off[CW+4:5];
    a_idx  = off[4:3];
    if (ch_hit)              rd_val = words[a_ch][a_idx];
    else if (addr == SRC_A)  rd_val = DW'(irq_src);
    else                     rd_val = '0;  // error type word and holes
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++)
        for (int w = 0; w < WORDS_PER_CH; w++)
          words[c][w] <= '0;
      irq_src <= '0;
      rdata   <= '0;
    end else begin
      rdata <= rd_val;
      if (upd) begin
        words[upd_ch][WORD_FLAGS] <= upd_flags;
        words[upd_ch][WORD_COUNT] <= upd_count;
        if (upd_err) irq_src[upd_ch] <= 1'b1;
      end
      // a software write lands after the service update and wins
      if (wr && ch_hit) words[a_ch][a_idx] <= wdata;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_view
    assign flags_o[g] = words[g][WORD_FLAGS];
    assign count_o[g] = words[g][WORD_COUNT];
    assign addr_o[g]  = words[g][WORD_ADDR];
  end
  assign irq_src_o = irq_src;
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl #(
  parameter int NCH = 8,
  parameter int DW  = 32,
  parameter int AW  = 10,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NCH-1:0]    req_valid,
  input  logic [NCH-1:0]    req_to_dev,
  input  logic [NCH*DW-1:0] req_len,
  output logic [NCH-1:0]    req_done,
  output logic [NCH-1:0]    req_err,
  output logic              mem_cmd_valid,
  output logic [CW-1:0]     mem_cmd_chan,
  output logic [DW-1:0]     mem_cmd_addr,
  output logic [DW-1:0]     mem_cmd_len,
  output logic              mem_cmd_to_dev
);
  logic [DW-1:0]  flags_w [NCH];
  logic [DW-1:0]  count_w [NCH];
  logic [DW-1:0]  addr_w  [NCH];
  logic [NCH-1:0] irq_src;
  logic           busy;
  logic [NCH-1:0] gnt;
  logic [CW-1:0]  g_idx;
  logic           take;
  logic           ok;
  logic [DW-1:0]  xlen, new_flags, new_count;

  // the cycle a pulse is out, the requester is still dropping its line
  assign busy = (|req_done) | (|req_err);

  dma_prio_arb #(.N(NCH)) u_arb (
    .req     (req_valid & {NCH{~busy}}),
    .gnt     (gnt),
    .gnt_idx (g_idx),
    .any     (take)
  );

  dma_xfer_eval #(.DW(DW)) u_eval (
    .flags     (flags_w[g_idx]),
    .count     (count_w[g_idx]),
    .len       (req_len[g_idx*DW +: DW]),
    .to_dev    (req_to_dev[g_idx]),
    .ok        (ok),
    .xlen      (xlen),
    .new_flags (new_flags),
    .new_count (new_count)
  );

  dma_chan_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .upd       (take),
    .upd_ch    (g_idx),
    .upd_err   (!ok),
    .upd_flags (new_flags),
    .upd_count (new_count),
    .flags_o   (flags_w),
    .count_o   (count_w),
    .addr_o    (addr_w),
    .irq_src_o (irq_src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_done       <= '0;
      req_err        <= '0;
      mem_cmd_valid  <= 1'b0;
      mem_cmd_chan   <= '0;
      mem_cmd_addr   <= '0;
      mem_cmd_len    <= '0;
      mem_cmd_to_dev <= 1'b0;
    end else begin
      req_done      <= (take && ok)  ? gnt : '0;
      req_err       <= (take && !ok) ? gnt : '0;
      mem_cmd_valid <= take && ok;
      if (take && ok) begin
        mem_cmd_chan   <= g_idx;
        mem_cmd_addr   <= addr_w[g_idx];
        mem_cmd_len    <= xlen;
        mem_cmd_to_dev <= req_to_dev[g_idx];
      end
    end
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] req_valid,
  input logic [NCH-1:0] req_done,
  input logic [NCH-1:0] req_err,
  input logic           mem_cmd_valid,
  input logic [CW-1:0]  mem_cmd_chan,
  input logic [NCH-1:0] irq_src
);
  logic [NCH-1:0] served;
  assign served = req_done | req_err;

  // R10
  one_served_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(served));

  // R10
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (|served) |=> !(|served));

  // R10
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    (|served) |-> (($past(req_valid) & (served - NCH'(1))) == '0));

  // R8
  served_was_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (|served) |-> (($past(req_valid) & served) == served));

  // R8
  done_with_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_cmd_valid |-> (req_done == (NCH'(1) << mem_cmd_chan)));

  // R5
  err_without_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_err) |-> !mem_cmd_valid);

  // R9
  err_sets_src_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_err) |-> ((req_err & irq_src) == req_err));

  // R9
  src_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((irq_src & $past(irq_src)) == $past(irq_src)));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_done      (req_done),
  .req_err       (req_err),
  .mem_cmd_valid (mem_cmd_valid),
  .mem_cmd_chan  (mem_cmd_chan),
  .irq_src       (irq_src)
);

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;
  localparam int NCH = 8;
  localparam int DW  = 32;
  localparam int AW  = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic [AW-1:0]     reg_addr = '0;
  logic [DW-1:0]     reg_wdata = '0;
  logic [DW-1:0]     reg_rdata;
  logic [NCH-1:0]    req_valid = '0;
  logic [NCH-1:0]    req_to_dev = '0;
  logic [NCH*DW-1:0] req_len = '0;
  logic [NCH-1:0]    req_done, req_err;
  logic              mem_cmd_valid, mem_cmd_to_dev;
  logic [2:0]        mem_cmd_chan;
  logic [DW-1:0]     mem_cmd_addr, mem_cmd_len;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_chan_ctrl #(.NCH(NCH), .DW(DW), .AW(AW)) uut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] cw(int ch, int w);
    return AW'('h100 + ch * 32 + w * 8);
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic prog(int ch, logic [31:0] fl, logic [31:0] cnt, logic [31:0] ad);
    wr(cw(ch, 1), fl);
    wr(cw(ch, 2), cnt);
    wr(cw(ch, 3), ad);
  endtask

  // raise one request, sample the pulses one clock later, release
  logic [NCH-1:0] c_done, c_err;
  logic           c_v, c_dir;
  logic [2:0]     c_ch;
  logic [31:0]    c_addr, c_len;
  task automatic do_req(int ch, logic [31:0] len, logic dir);
    @(negedge clk);
    req_valid[ch] = 1'b1; req_to_dev[ch] = dir; req_len[ch*DW +: DW] = len;
    @(negedge clk);
    c_done = req_done; c_err = req_err; c_v = mem_cmd_valid;
    c_ch = mem_cmd_chan; c_addr = mem_cmd_addr; c_len = mem_cmd_len; c_dir = mem_cmd_to_dev;
    req_valid[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 done idle", 32'(req_done), 0);
    check("R1 err idle", 32'(req_err), 0);
    check("R1 cmd idle", 32'(mem_cmd_valid), 0);
    for (int c = 0; c < NCH; c++) begin
      rd(cw(c, 1), d); check("R1 flags zero", d, 0);
      rd(cw(c, 2), d); check("R1 count zero", d, 0);
    end
    rd('h200, d); check("R1 src zero", d, 0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 4; w++)
        wr(cw(c, w), 32'hA500_0000 | (c << 8) | w);
    for (int c = 0; c < NCH; c++)
      for (int w = 0; w < 4; w++) begin
        rd(cw(c, w), d); check("R2 readback", d, 32'hA500_0000 | (c << 8) | w);
      end
  endtask

  task automatic t_ignored;
    logic [31:0] d;
    wr('h104, 32'hDEAD_BEEF);
    rd('h104, d); check("R3 misaligned reads zero", d, 0);
    rd('h100, d); check("R3 misaligned write no effect", d, 32'hA500_0000);
    wr('h200, 32'hFF);
    rd('h200, d); check("R3 src write ignored", d, 0);
    wr('h208, 32'h1234);
    rd('h208, d); check("R3 error type zero", d, 0);
    wr('h2F8, 32'h55);
    rd('h2F8, d); check("R3 unmapped zero", d, 0);
  endtask

  task automatic t_good;
    logic [31:0] d;
    prog(3, 32'h701, 100, 32'h1234_5000);
    do_req(3, 40, 1'b0);
    check("R8 done ch3", 32'(c_done), 32'h08);
    check("R8 no err", 32'(c_err), 0);
    check("R7 cmd valid", 32'(c_v), 1);
    check("R7 cmd chan", 32'(c_ch), 3);
    check("R7 cmd addr", c_addr, 32'h1234_5000);
    check("R7 cmd len", c_len, 40);
    check("R7 cmd dir", 32'(c_dir), 0);
    rd(cw(3, 1), d); check("R4 flags cleared then tc", d, 32'h101);
    rd(cw(3, 2), d); check("R8 count", d, 60);
    rd(cw(3, 3), d); check("R7 addr unchanged", d, 32'h1234_5000);
  endtask

  task automatic t_clamp;
    logic [31:0] d;
    do_req(3, 100, 1'b0);
    check("R7 clamp len", c_len, 60);
    rd(cw(3, 2), d); check("R8 count drained", d, 0);
    do_req(3, 5, 1'b0);
    check("R7 zero len", c_len, 0);
    check("R8 done at zero count", 32'(c_done), 32'h08);
  endtask

  task automatic t_to_dev;
    logic [31:0] d;
    prog(6, 32'h3, 16, 32'h8000_0000);
    do_req(6, 8, 1'b1);
    check("R7 to_dev done", 32'(c_done), 32'h40);
    check("R7 to_dev dir", 32'(c_dir), 1);
    check("R7 to_dev addr", c_addr, 32'h8000_0000);
    rd(cw(6, 2), d); check("R8 to_dev count", d, 8);
  endtask

  task automatic t_disabled;
    logic [31:0] d;
    prog(1, 32'h502, 50, 32'h4000);
    do_req(1, 10, 1'b1);
    check("R5 err ch1", 32'(c_err), 32'h02);
    check("R5 no done", 32'(c_done), 0);
    check("R5 no cmd", 32'(c_v), 0);
    rd(cw(1, 1), d); check("R5 flags merr", d, 32'h202);
    rd(cw(1, 2), d); check("R5 count kept", d, 50);
    rd('h200, d); check("R9 src ch1", d, 32'h02);
  endtask

  task automatic t_dir_mismatch;
    logic [31:0] d;
    prog(4, 32'h001, 30, 32'h5000);
    do_req(4, 10, 1'b1);
    check("R6 err ch4", 32'(c_err), 32'h10);
    check("R6 no cmd", 32'(c_v), 0);
    rd(cw(4, 1), d); check("R6 flags merr", d, 32'h201);
    rd(cw(4, 2), d); check("R6 count kept", d, 30);
    rd('h200, d); check("R9 src accumulates", d, 32'h12);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    prog(2, 32'h1, 10, 32'hA000);
    prog(5, 32'h1, 10, 32'hB000);
    @(negedge clk);
    req_valid[2] = 1'b1; req_valid[5] = 1'b1;
    req_to_dev[2] = 1'b0; req_to_dev[5] = 1'b0;
    req_len[2*DW +: DW] = 4; req_len[5*DW +: DW] = 6;
    @(negedge clk);
    check("R10 lowest first", 32'(req_done), 32'h04);
    check("R10 first addr", mem_cmd_addr, 32'hA000);
    req_valid[2] = 1'b0;
    @(negedge clk);
    check("R10 gap after pulse", 32'(req_done | req_err), 0);
    @(negedge clk);
    check("R10 second served", 32'(req_done), 32'h20);
    check("R10 second len", mem_cmd_len, 6);
    req_valid[5] = 1'b0;
    @(negedge clk);
    rd('h200, d); check("R9 src sticky after successes", d, 32'h12);
  endtask

  task automatic t_rereset;
    logic [31:0] d;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd('h200, d); check("R1 src cleared by reset", d, 0);
    rd(cw(3, 3), d); check("R1 addr cleared by reset", d, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_ignored();
    t_good();
    t_clamp();
    t_to_dev();
    t_disabled();
    t_dir_mismatch();
    t_priority();
    t_rereset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule